// File: doc/BRIEF.md
# Video Register Bank with Bus Width Adapter

This block is the register file of a video output controller. It is built around 16-bit registers but sits on a bus that can issue 8-bit, 16-bit and 32-bit accesses inside a 4 KiB window. Byte reads are served from the matching halfword. Byte writes are refused. A 32-bit access is handled as two halfword accesses at consecutive halfword addresses, and both are performed in the same clock cycle.

The bank holds five kinds of register:
- a display control register, where software may change only some fields, plus a self-clearing reset command;
- four framebuffer address registers, arranged as a left top/bottom pair and a right top/bottom pair;
- four display interrupt registers, each with a flag and a mask;
- a 32-bit auxiliary register, accessed as two halves.

Several registers have side effects on write. A control reset wipes every interrupt register. A clear-page-offset request forces a framebuffer register's page-offset bit to zero. A timing generator outside the block sets interrupt flags through a strobe input. The block ORs the unmasked flags into one interrupt line. It also drives the effective framebuffer addresses, which are shifted by the top register's page-offset bit.

Top module: `vreg_regfile`

## Requirements
- R1: An 8-bit read at an even address returns the upper byte of the halfword at that address in bus_rdata_o[7:0]. An 8-bit read at the next odd address returns the lower byte. Bits 31:8 read as zero. The size encoding is 0 = 8-bit, 1 = 16-bit, 2 = 32-bit.
- R2: An 8-bit write changes no register and no output.
- R3: A 32-bit write at halfword address A writes bus_wdata_i[31:16] to A and bus_wdata_i[15:0] to A+2. A 32-bit read at A returns {halfword(A), halfword(A+2)}.
- R4: The control register sits at 0x000 and resets to 0x2C01. A write updates only bits 0, 2, 3, 7:4 and 9:8 (mask 0x03FD). Bits 15:10 keep their stored value.
- R5: Writing 1 to control bit 1 clears all four interrupt registers, flags included. The clear wins over a hardware set in the same cycle. Bit 1 always reads 0, and irq_o is low in the following cycle.
- R6: The framebuffer registers have their upper half at 0x010+4n and their lower half at 0x012+4n, with n = 0 left top, 1 left bottom, 2 right top, 3 right bottom. Writing an upper half with bit 13 set stores bit 12 (page offset) as 0.
- R7: The effective address of register n is its bits 23:0 (the base). The base is shifted left by 5 when the page-offset bit of the pair's top register is 1, and left unshifted otherwise. A bottom register always uses its top register's bit, never its own.
- R8: The auxiliary register has its upper half at 0x030 and its lower half at 0x032. A write to either half leaves the other half unchanged.
- R9: Interrupt register n has its upper half at 0x020+4n and its lower half at 0x022+4n. In the upper half, bit 15 is the flag and bit 12 is the mask. A write to the upper half loads the flag from the data. irq_set_i[n] sets the flag, and it wins over a same-cycle write. irq_o is the OR of flag AND mask and follows in the next cycle.
- R10: Reads of unmapped addresses return zero. Size code 3 reads zero and writes nothing.
- R11: Register updates take effect at the clock edge that samples the write. bus_rdata_o is registered with one cycle of latency and holds its value on cycles without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_req_i | input | 1 | Access request, one cycle per access |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_size_i | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| bus_addr_i | input | ADDR_W | Byte address within the window |
| bus_wdata_i | input | 32 | Write data (halfword in bits 15:0) |
| bus_rdata_o | output | 32 | Registered read data |
| irq_set_i | input | 4 | Per-register interrupt flag set strobes |
| irq_o | output | 1 | Combined masked interrupt |
| fb_ltop_o | output | BASE_W+PG_SHIFT | Effective left top address |
| fb_lbot_o | output | BASE_W+PG_SHIFT | Effective left bottom address |
| fb_rtop_o | output | BASE_W+PG_SHIFT | Effective right top address |
| fb_rbot_o | output | BASE_W+PG_SHIFT | Effective right bottom address |

## Verification
Two pairs of functions can collide in one cycle:
- A hardware flag strobe against a software write to the same interrupt register's upper half. The bench drives irq_set_i together with a write that clears the flag, and expects the flag to survive.
- A hardware flag strobe against a control reset. The bench raises all four strobes in the same cycle as the reset write, and expects every interrupt register to read zero and irq_o to be low.

Around these collisions, a near-exhaustive sweep writes every halfword of the mapped range in turn. After each write, the bench reads back the whole range at byte and halfword width and compares it with a model computed from the requirements.

// File: rtl/vreg_pkg.sv
// Package: vreg_pkg
// Shared constants and types for the video register bank: the register
// offsets, the field bit positions, the bus size codes and the per-halfword
// select structure.
package vreg_pkg;

    localparam int NUM_FB   = 4;
    localparam int NUM_IRQ  = 4;

    localparam int OFS_CTRL = 'h000;
    localparam int OFS_FB   = 'h010;
    localparam int OFS_IRQ  = 'h020;
    localparam int OFS_AUX  = 'h030;

    localparam logic [15:0] CTRL_WMASK = 16'h03FD;
    localparam int CTRL_RST_BIT = 1;
    localparam int FB_POFS_BIT  = 12;
    localparam int FB_CLRP_BIT  = 13;
    localparam int IRQ_FLAG_BIT = 15;
    localparam int IRQ_MASK_BIT = 12;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } bus_size_e;

    typedef struct packed {
        logic               ctrl;
        logic [NUM_FB-1:0]  fb_hi;
        logic [NUM_FB-1:0]  fb_lo;
        logic [NUM_IRQ-1:0] irq_hi;
        logic [NUM_IRQ-1:0] irq_lo;
        logic               aux_hi;
        logic               aux_lo;
    } hsel_t;

endpackage

// File: rtl/vreg_decode.sv
// Module: vreg_decode
// Decodes one halfword-aligned address into a one-hot register-half select.
// Assumes bit 0 of the address is already zero. An unmapped address gives an
// all-zero select.
module vreg_decode
    import vreg_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] haddr_i,
    output hsel_t             sel_o
);

    // Compare the address against every register-half offset.
    always_comb begin
        sel_o        = '0;
        sel_o.ctrl   = (haddr_i == ADDR_W'(OFS_CTRL));
        sel_o.aux_hi = (haddr_i == ADDR_W'(OFS_AUX));
        sel_o.aux_lo = (haddr_i == ADDR_W'(OFS_AUX + 2));
        for (int i = 0; i < NUM_FB; i++) begin
            sel_o.fb_hi[i] = (haddr_i == ADDR_W'(OFS_FB + 4 * i));
            sel_o.fb_lo[i] = (haddr_i == ADDR_W'(OFS_FB + 4 * i + 2));
        end
        for (int i = 0; i < NUM_IRQ; i++) begin
            sel_o.irq_hi[i] = (haddr_i == ADDR_W'(OFS_IRQ + 4 * i));
            sel_o.irq_lo[i] = (haddr_i == ADDR_W'(OFS_IRQ + 4 * i + 2));
        end
    end

endmodule

// File: rtl/vreg_fb_bank.sv
// Module: vreg_fb_bank
// Holds the four framebuffer address registers and derives their effective
// addresses. Write selects arrive already gated by the write enable. The two
// lanes never select the same half in one cycle.
module vreg_fb_bank
    import vreg_pkg::*;
#(
    parameter int BASE_W   = 24,
    parameter int PG_SHIFT = 5,
    parameter int EFF_W    = BASE_W + PG_SHIFT
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  hsel_t                          wsel0_i,
    input  hsel_t                          wsel1_i,
    input  logic [15:0]                    wd0_i,
    input  logic [15:0]                    wd1_i,
    output logic [NUM_FB-1:0][31:0]        regs_o,
    output logic [NUM_FB-1:0][EFF_W-1:0]   eff_o
);

    localparam int POFS_POS = 16 + FB_POFS_BIT;

    for (genvar g = 0; g < NUM_FB; g++) begin : g_fb
        localparam int TOPI = (g / 2) * 2;
        logic        hi_we, lo_we;
        logic [15:0] hi_d, lo_d;
        logic [31:0] r;

        assign hi_we = wsel0_i.fb_hi[g] | wsel1_i.fb_hi[g];
        assign lo_we = wsel0_i.fb_lo[g] | wsel1_i.fb_lo[g];
        assign hi_d  = wsel0_i.fb_hi[g] ? wd0_i : wd1_i;
        assign lo_d  = wsel0_i.fb_lo[g] ? wd0_i : wd1_i;

        // Store the halves; a clear-page-offset request zeroes the page bit.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                r <= '0;
            end else begin
                if (hi_we) begin
                    r[31:16] <= hi_d;
                    if (hi_d[FB_CLRP_BIT]) begin
                        r[POFS_POS] <= 1'b0;
                    end
                end
                if (lo_we) begin
                    r[15:0] <= lo_d;
                end
            end
        end

        assign regs_o[g] = r;

        // Scale the base by the page-offset bit of the pair's top register.
        assign eff_o[g] = regs_o[TOPI][POFS_POS]
                        ? {regs_o[g][BASE_W-1:0], {PG_SHIFT{1'b0}}}
                        : EFF_W'(regs_o[g][BASE_W-1:0]);
    end

endmodule

// File: rtl/vreg_irq_bank.sv
// Module: vreg_irq_bank
// Holds the four display interrupt registers and forms the combined
// interrupt. Priority: wipe, then hardware set, then software write of the
// flag. Write selects arrive already gated by the write enable.
module vreg_irq_bank
    import vreg_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  hsel_t                    wsel0_i,
    input  hsel_t                    wsel1_i,
    input  logic [15:0]              wd0_i,
    input  logic [15:0]              wd1_i,
    input  logic [NUM_IRQ-1:0]       set_i,
    input  logic                     wipe_i,
    output logic [NUM_IRQ-1:0][31:0] regs_o,
    output logic                     irq_o
);

    localparam int FLAG_POS = 16 + IRQ_FLAG_BIT;
    localparam int MASK_POS = 16 + IRQ_MASK_BIT;

    logic [NUM_IRQ-1:0] pend;

    for (genvar g = 0; g < NUM_IRQ; g++) begin : g_irq
        logic        hi_we, lo_we;
        logic [15:0] hi_d, lo_d;
        logic [31:0] r;

        assign hi_we = wsel0_i.irq_hi[g] | wsel1_i.irq_hi[g];
        assign lo_we = wsel0_i.irq_lo[g] | wsel1_i.irq_lo[g];
        assign hi_d  = wsel0_i.irq_hi[g] ? wd0_i : wd1_i;
        assign lo_d  = wsel0_i.irq_lo[g] ? wd0_i : wd1_i;

        // Update one interrupt register under the wipe/set/write priority.
        always_ff @(posedge clk) begin
            if (!rst_n || wipe_i) begin
                r <= '0;
            end else begin
                if (hi_we) begin
                    r[31:16] <= hi_d;
                end
                if (lo_we) begin
                    r[15:0] <= lo_d;
                end
                if (set_i[g]) begin
                    r[FLAG_POS] <= 1'b1;
                end
            end
        end

        assign regs_o[g] = r;
        assign pend[g]   = r[FLAG_POS] & r[MASK_POS];
    end

    // Combine the masked flags into one line.
    assign irq_o = |pend;

endmodule

// File: rtl/vreg_regfile.sv
// Module: vreg_regfile
// Top level of the video register bank. It splits each bus access into two
// halfword lanes (lane 1 is active only for 32-bit accesses), holds the
// control and auxiliary registers, and registers the read data.
// Assumes one access per request cycle and a halfword-aligned address for
// 16-bit and 32-bit accesses.
module vreg_regfile
    import vreg_pkg::*;
#(
    parameter int          ADDR_W    = 12,
    parameter int          BASE_W    = 24,
    parameter int          PG_SHIFT  = 5,
    parameter logic [15:0] CTRL_INIT = 16'h2C01
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_req_i,
    input  logic                       bus_we_i,
    input  logic [1:0]                 bus_size_i,
    input  logic [ADDR_W-1:0]          bus_addr_i,
    input  logic [31:0]                bus_wdata_i,
    output logic [31:0]                bus_rdata_o,
    input  logic [NUM_IRQ-1:0]         irq_set_i,
    output logic                       irq_o,
    output logic [BASE_W+PG_SHIFT-1:0] fb_ltop_o,
    output logic [BASE_W+PG_SHIFT-1:0] fb_lbot_o,
    output logic [BASE_W+PG_SHIFT-1:0] fb_rtop_o,
    output logic [BASE_W+PG_SHIFT-1:0] fb_rbot_o
);

    localparam int LANES = 2;
    localparam int EFF_W = BASE_W + PG_SHIFT;
    localparam logic [15:0] CTRL_RST_VAL = CTRL_INIT & ~(16'h1 << CTRL_RST_BIT);

    logic                           is_half, is_word;
    logic [ADDR_W-1:0]              base_addr;
    logic [LANES-1:0][ADDR_W-1:0]   lane_addr;
    logic [LANES-1:0][15:0]         lane_wd;
    logic [LANES-1:0]               lane_we;
    hsel_t [LANES-1:0]              lane_sel;
    hsel_t [LANES-1:0]              lane_wsel;
    logic [LANES-1:0][15:0]         lane_rd;

    logic [15:0]                    ctrl_q, ctrl_d;
    logic                           ctrl_we, wipe;
    logic [31:0]                    aux_q;
    logic [NUM_FB-1:0][31:0]        fb_regs;
    logic [NUM_FB-1:0][EFF_W-1:0]   fb_eff;
    logic [NUM_IRQ-1:0][31:0]       irq_regs;
    logic [31:0]                    rd_next;

    // Split the access into its two halfword lanes.
    assign is_half      = (bus_size_i == SZ_HALF);
    assign is_word      = (bus_size_i == SZ_WORD);
    assign base_addr    = {bus_addr_i[ADDR_W-1:1], 1'b0};
    assign lane_addr[0] = base_addr;
    assign lane_addr[1] = base_addr + ADDR_W'(2);
    assign lane_wd[0]   = is_word ? bus_wdata_i[31:16] : bus_wdata_i[15:0];
    assign lane_wd[1]   = bus_wdata_i[15:0];
    assign lane_we[0]   = bus_req_i & bus_we_i & (is_half | is_word);
    assign lane_we[1]   = bus_req_i & bus_we_i & is_word;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        vreg_decode #(.ADDR_W(ADDR_W)) u_dec (
            .haddr_i (lane_addr[l]),
            .sel_o   (lane_sel[l])
        );

        assign lane_wsel[l] = lane_we[l] ? lane_sel[l] : '0;

        // Gather the halfword this lane addresses; unmapped gives zero.
        always_comb begin
            lane_rd[l] = '0;
            if (lane_sel[l].ctrl)   lane_rd[l] = lane_rd[l] | ctrl_q;
            if (lane_sel[l].aux_hi) lane_rd[l] = lane_rd[l] | aux_q[31:16];
            if (lane_sel[l].aux_lo) lane_rd[l] = lane_rd[l] | aux_q[15:0];
            for (int i = 0; i < NUM_FB; i++) begin
                if (lane_sel[l].fb_hi[i]) lane_rd[l] = lane_rd[l] | fb_regs[i][31:16];
                if (lane_sel[l].fb_lo[i]) lane_rd[l] = lane_rd[l] | fb_regs[i][15:0];
            end
            for (int i = 0; i < NUM_IRQ; i++) begin
                if (lane_sel[l].irq_hi[i]) lane_rd[l] = lane_rd[l] | irq_regs[i][31:16];
                if (lane_sel[l].irq_lo[i]) lane_rd[l] = lane_rd[l] | irq_regs[i][15:0];
            end
        end
    end

    // Control register write data and the reset command.
    assign ctrl_we = lane_wsel[0].ctrl | lane_wsel[1].ctrl;
    assign ctrl_d  = lane_wsel[0].ctrl ? lane_wd[0] : lane_wd[1];
    assign wipe    = ctrl_we & ctrl_d[CTRL_RST_BIT];

    // Control register: only the writable fields follow a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RST_VAL;
        end else if (ctrl_we) begin
            ctrl_q <= (ctrl_q & ~CTRL_WMASK) | (ctrl_d & CTRL_WMASK);
        end
    end

    // Auxiliary register: halves are written independently.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            aux_q <= '0;
        end else begin
            if (lane_wsel[0].aux_hi | lane_wsel[1].aux_hi) begin
                aux_q[31:16] <= lane_wsel[0].aux_hi ? lane_wd[0] : lane_wd[1];
            end
            if (lane_wsel[0].aux_lo | lane_wsel[1].aux_lo) begin
                aux_q[15:0] <= lane_wsel[0].aux_lo ? lane_wd[0] : lane_wd[1];
            end
        end
    end

    vreg_fb_bank #(
        .BASE_W   (BASE_W),
        .PG_SHIFT (PG_SHIFT),
        .EFF_W    (EFF_W)
    ) u_fb (
        .clk     (clk),
        .rst_n   (rst_n),
        .wsel0_i (lane_wsel[0]),
        .wsel1_i (lane_wsel[1]),
        .wd0_i   (lane_wd[0]),
        .wd1_i   (lane_wd[1]),
        .regs_o  (fb_regs),
        .eff_o   (fb_eff)
    );

    vreg_irq_bank u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .wsel0_i (lane_wsel[0]),
        .wsel1_i (lane_wsel[1]),
        .wd0_i   (lane_wd[0]),
        .wd1_i   (lane_wd[1]),
        .set_i   (irq_set_i),
        .wipe_i  (wipe),
        .regs_o  (irq_regs),
        .irq_o   (irq_o)
    );

    assign fb_ltop_o = fb_eff[0];
    assign fb_lbot_o = fb_eff[1];
    assign fb_rtop_o = fb_eff[2];
    assign fb_rbot_o = fb_eff[3];

    // Shape the read data according to the access size.
    always_comb begin
        case (bus_size_i)
            SZ_BYTE: rd_next = {24'h0, bus_addr_i[0] ? lane_rd[0][7:0] : lane_rd[0][15:8]};
            SZ_HALF: rd_next = {16'h0, lane_rd[0]};
            SZ_WORD: rd_next = {lane_rd[0], lane_rd[1]};
            default: rd_next = '0;
        endcase
    end

    // Read data register: loads on a read, holds otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata_o <= '0;
        end else if (bus_req_i && !bus_we_i) begin
            bus_rdata_o <= rd_next;
        end
    end

endmodule

// File: rtl/vreg_regfile_chk.sv
// Module: vreg_regfile_chk
// Property checker for vreg_regfile. It watches only the ports and is bound
// to every instance of the top module.
module vreg_regfile_chk
    import vreg_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int BASE_W   = 24,
    parameter int PG_SHIFT = 5
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       bus_req_i,
    input logic                       bus_we_i,
    input logic [1:0]                 bus_size_i,
    input logic [ADDR_W-1:0]          bus_addr_i,
    input logic [31:0]                bus_wdata_i,
    input logic [31:0]                bus_rdata_o,
    input logic [NUM_IRQ-1:0]         irq_set_i,
    input logic                       irq_o,
    input logic [BASE_W+PG_SHIFT-1:0] fb_ltop_o,
    input logic [BASE_W+PG_SHIFT-1:0] fb_lbot_o,
    input logic [BASE_W+PG_SHIFT-1:0] fb_rtop_o,
    input logic [BASE_W+PG_SHIFT-1:0] fb_rbot_o
);

    logic half_wr, half_rd, byte_wr;
    assign half_wr = bus_req_i && bus_we_i && (bus_size_i == SZ_HALF);
    assign half_rd = bus_req_i && !bus_we_i && (bus_size_i == SZ_HALF);
    assign byte_wr = bus_req_i && bus_we_i && (bus_size_i == SZ_BYTE);

    // R5
    reset_wipes_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (half_wr && bus_addr_i == ADDR_W'(OFS_CTRL) && bus_wdata_i[CTRL_RST_BIT]) |=> !irq_o);

    // R4
    ctrl_rst_bit_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (half_rd && bus_addr_i == ADDR_W'(OFS_CTRL)) |=> (bus_rdata_o[31:16] == 16'h0 && !bus_rdata_o[CTRL_RST_BIT]));

    // R11
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_req_i && !bus_we_i) |=> $stable(bus_rdata_o));

    // R2
    byte_write_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_wr && irq_set_i == '0) |=> ($stable(fb_ltop_o) && $stable(fb_lbot_o) &&
                                          $stable(fb_rtop_o) && $stable(fb_rbot_o) && $stable(irq_o)));

    // R6
    clear_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (half_wr && bus_addr_i == ADDR_W'(OFS_FB) && bus_wdata_i[FB_CLRP_BIT])
        |=> ((fb_ltop_o >> BASE_W) == '0 && (fb_lbot_o >> BASE_W) == '0));

    // R7
    page_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (half_wr && bus_addr_i == ADDR_W'(OFS_FB) && bus_wdata_i[FB_POFS_BIT] && !bus_wdata_i[FB_CLRP_BIT])
        |=> (fb_ltop_o[PG_SHIFT-1:0] == '0 && fb_lbot_o[PG_SHIFT-1:0] == '0));

endmodule

bind vreg_regfile vreg_regfile_chk #(
    .ADDR_W   (ADDR_W),
    .BASE_W   (BASE_W),
    .PG_SHIFT (PG_SHIFT)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_req_i   (bus_req_i),
    .bus_we_i    (bus_we_i),
    .bus_size_i  (bus_size_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_rdata_o (bus_rdata_o),
    .irq_set_i   (irq_set_i),
    .irq_o       (irq_o),
    .fb_ltop_o   (fb_ltop_o),
    .fb_lbot_o   (fb_lbot_o),
    .fb_rtop_o   (fb_rtop_o),
    .fb_rbot_o   (fb_rbot_o)
);

// File: tb/vreg_regfile_tb.sv
`timescale 1ns/1ps
// Bench for vreg_regfile. A register model built from the requirements
// predicts every read; halfword sweeps cover the mapped range.
module vreg_regfile_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0, we = 1'b0;
    logic [1:0]  sz = 2'd0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [3:0]  iset = '0;
    logic [31:0] rdata;
    logic        irq;
    logic [28:0] ltop, lbot, rtop, rbot;

    int nvec = 0, nerr = 0;
    logic done = 1'b0;

    always #4 clk = ~clk;

    vreg_regfile u_dut (
        .clk(clk), .rst_n(rst_n), .bus_req_i(req), .bus_we_i(we),
        .bus_size_i(sz), .bus_addr_i(addr), .bus_wdata_i(wdata),
        .bus_rdata_o(rdata), .irq_set_i(iset), .irq_o(irq),
        .fb_ltop_o(ltop), .fb_lbot_o(lbot), .fb_rtop_o(rtop), .fb_rbot_o(rbot)
    );

    // Register model
    logic [15:0] m_ctrl;
    logic [31:0] m_fb [4];
    logic [31:0] m_irq [4];
    logic [31:0] m_aux;
    logic        m_wiped;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] mread(input logic [11:0] a);
        if (a == 12'h000) return m_ctrl;
        if (a == 12'h030) return m_aux[31:16];
        if (a == 12'h032) return m_aux[15:0];
        for (int i = 0; i < 4; i++) begin
            if (a == 12'(16 + 4 * i)) return m_fb[i][31:16];
            if (a == 12'(18 + 4 * i)) return m_fb[i][15:0];
            if (a == 12'(32 + 4 * i)) return m_irq[i][31:16];
            if (a == 12'(34 + 4 * i)) return m_irq[i][15:0];
        end
        return 16'h0;
    endfunction

    task automatic mwrite(input logic [11:0] a, input logic [15:0] d);
        if (a == 12'h000) begin
            m_ctrl = (m_ctrl & ~16'h03FD) | (d & 16'h03FD);
            if (d[1]) begin
                for (int i = 0; i < 4; i++) m_irq[i] = '0;
                m_wiped = 1'b1;
            end
        end
        if (a == 12'h030) m_aux[31:16] = d;
        if (a == 12'h032) m_aux[15:0] = d;
        for (int i = 0; i < 4; i++) begin
            if (a == 12'(16 + 4 * i)) begin
                m_fb[i][31:16] = d;
                if (d[13]) m_fb[i][28] = 1'b0;
            end
            if (a == 12'(18 + 4 * i)) m_fb[i][15:0] = d;
            if (a == 12'(32 + 4 * i)) m_irq[i][31:16] = d;
            if (a == 12'(34 + 4 * i)) m_irq[i][15:0] = d;
        end
    endtask

    function automatic logic exp_irq();
        logic r = 1'b0;
        for (int i = 0; i < 4; i++) r = r | (m_irq[i][31] & m_irq[i][28]);
        return r;
    endfunction

    function automatic logic [28:0] exp_eff(input int i);
        logic [23:0] b = m_fb[i][23:0];
        return m_fb[(i / 2) * 2][28] ? {b, 5'b0} : {5'b0, b};
    endfunction

    function automatic logic [31:0] exp_rd(input logic [1:0] s, input logic [11:0] a);
        logic [11:0] b = {a[11:1], 1'b0};
        logic [15:0] h0 = mread(b);
        logic [15:0] h1 = mread(b + 12'd2);
        case (s)
            2'd0: return {24'h0, a[0] ? h0[7:0] : h0[15:8]};
            2'd1: return {16'h0, h0};
            2'd2: return {h0, h1};
            default: return 32'h0;
        endcase
    endfunction

    // One bus cycle (or a strobe-only cycle when rq is 0), with the model updated.
    task automatic op(input logic rq, input logic w, input logic [1:0] s,
                      input logic [11:0] a, input logic [31:0] d, input logic [3:0] st);
        logic [11:0] b = {a[11:1], 1'b0};
        @(negedge clk);
        req = rq; we = w; sz = s; addr = a; wdata = d; iset = st;
        @(negedge clk);
        req = 1'b0; we = 1'b0; iset = '0;
        m_wiped = 1'b0;
        if (rq && w && s == 2'd1) mwrite(b, d[15:0]);
        if (rq && w && s == 2'd2) begin
            mwrite(b, d[31:16]);
            mwrite(b + 12'd2, d[15:0]);
        end
        for (int n = 0; n < 4; n++)
            if (st[n] && !m_wiped) m_irq[n][31] = 1'b1;
    endtask

    task automatic rdchk(input string tag, input logic [1:0] s, input logic [11:0] a);
        logic [31:0] e = exp_rd(s, a);
        op(1'b1, 1'b0, s, a, 32'h0, 4'h0);
        chk($sformatf("%s size%0d @%h", tag, s, a), rdata, e);
    endtask

    task automatic outchk(input string tag);
        chk({tag, " R9 irq_o"}, {31'h0, irq}, {31'h0, exp_irq()});
        chk({tag, " R7 ltop"}, {3'h0, ltop}, {3'h0, exp_eff(0)});
        chk({tag, " R7 lbot"}, {3'h0, lbot}, {3'h0, exp_eff(1)});
        chk({tag, " R7 rtop"}, {3'h0, rtop}, {3'h0, exp_eff(2)});
        chk({tag, " R7 rbot"}, {3'h0, rbot}, {3'h0, exp_eff(3)});
    endtask

    task automatic check_all(input string tag);
        outchk(tag);
        for (int b = 0; b < 64; b += 2) begin
            rdchk({tag, " R11 half"}, 2'd1, 12'(b));
            rdchk({tag, " R1 byte"}, 2'd0, 12'(b));
            rdchk({tag, " R1 byte"}, 2'd0, 12'(b + 1));
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            nerr++; nvec++;
            $display("FAIL watchdog expired");
            $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] held;
        m_ctrl = 16'h2C01; m_aux = '0; m_wiped = 1'b0;
        for (int i = 0; i < 4; i++) begin m_fb[i] = '0; m_irq[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // Reset state (R4, R11)
        chk("R11 rdata after reset", rdata, 32'h0);
        outchk("reset");
        rdchk("R4 ctrl reset value", 2'd1, 12'h000);
        chk("R4 ctrl literal", rdata, 32'h0000_2C01);

        // Halfword sweep over the mapped range (R6 R8 R9 R4)
        for (int a = 0; a < 64; a += 2) begin
            op(1'b1, 1'b1, 2'd1, 12'(a), {16'h0, 16'hA5C3 ^ 16'(a * 16'h1357)}, 4'h0);
            check_all($sformatf("sweep16 @%h", a));
        end

        // Word writes and reads (R3)
        for (int a = 0; a < 64; a += 4) begin
            op(1'b1, 1'b1, 2'd2, 12'(a), 32'h5A3C_96E1 ^ (32'(a) * 32'h0101_0309), 4'h0);
            outchk("R3 word write");
        end
        for (int a = 0; a < 64; a += 2) rdchk("R3 word read", 2'd2, 12'(a));
        op(1'b1, 1'b1, 2'd2, 12'h030, 32'hDEAD_BEEF, 4'h0);
        rdchk("R3 aux word", 2'd2, 12'h030);
        chk("R3 aux literal", rdata, 32'hDEAD_BEEF);

        // Byte writes are ignored (R2)
        for (int a = 0; a < 64; a++) op(1'b1, 1'b1, 2'd0, 12'(a), 32'hFFFF_FFFF, 4'h0);
        check_all("R2 after byte writes");

        // Control partial update (R4)
        op(1'b1, 1'b1, 2'd1, 12'h000, 32'h0000_FFFD, 4'h0);
        rdchk("R4 ctrl partial", 2'd1, 12'h000);
        chk("R4 ctrl partial literal", rdata, 32'h0000_2FFD);

        // Reset command against simultaneous hardware sets (R5)
        for (int i = 0; i < 4; i++) op(1'b1, 1'b1, 2'd1, 12'(32 + 4 * i), 32'h0000_9000, 4'h0);
        chk("R5 irq armed", {31'h0, irq}, 32'h1);
        op(1'b1, 1'b1, 2'd1, 12'h000, 32'h0000_0002, 4'hF);
        chk("R5 irq after wipe", {31'h0, irq}, 32'h0);
        for (int i = 0; i < 4; i++) begin
            rdchk("R5 irq reg wiped", 2'd2, 12'(32 + 4 * i));
            chk("R5 irq reg literal", rdata, 32'h0);
        end
        rdchk("R5 ctrl bit1 reads 0", 2'd1, 12'h000);

        // Flag handling and set/write collision (R9)
        op(1'b1, 1'b1, 2'd1, 12'h024, 32'h0000_1000, 4'h0);
        chk("R9 mask only", {31'h0, irq}, 32'h0);
        op(1'b0, 1'b0, 2'd0, 12'h000, 32'h0, 4'b0010);
        chk("R9 hw set", {31'h0, irq}, 32'h1);
        op(1'b1, 1'b1, 2'd1, 12'h024, 32'h0000_1000, 4'b0010);
        chk("R9 set beats clear", {31'h0, irq}, 32'h1);
        rdchk("R9 flag kept", 2'd1, 12'h024);
        chk("R9 flag literal", rdata, 32'h0000_9000);
        op(1'b1, 1'b1, 2'd1, 12'h024, 32'h0000_1000, 4'h0);
        chk("R9 sw clear", {31'h0, irq}, 32'h0);
        op(1'b0, 1'b0, 2'd0, 12'h000, 32'h0, 4'b0100);
        chk("R9 unmasked set", {31'h0, irq}, 32'h0);

        // Page offset and scaling (R6 R7)
        op(1'b1, 1'b1, 2'd2, 12'h010, 32'h10AB_1234, 4'h0);
        op(1'b1, 1'b1, 2'd2, 12'h014, 32'h00CD_5678, 4'h0);
        chk("R7 ltop shifted", {3'h0, ltop}, {3'h0, 24'hAB1234, 5'h0});
        chk("R7 lbot uses top bit", {3'h0, lbot}, {3'h0, 24'hCD5678, 5'h0});
        op(1'b1, 1'b1, 2'd1, 12'h014, 32'h0000_00CD, 4'h0);
        chk("R7 own bit ignored", {3'h0, lbot}, {3'h0, 24'hCD5678, 5'h0});
        op(1'b1, 1'b1, 2'd1, 12'h010, 32'h0000_30AB, 4'h0);
        chk("R6 clear page ltop", {3'h0, ltop}, {8'h0, 24'hAB1234});
        chk("R6 clear page lbot", {3'h0, lbot}, {8'h0, 24'hCD5678});
        rdchk("R6 page bit stored 0", 2'd1, 12'h010);
        chk("R6 readback literal", rdata, 32'h0000_20AB);
        outchk("R6 R7 final");

        // Auxiliary halves (R8)
        op(1'b1, 1'b1, 2'd1, 12'h032, 32'h0000_1111, 4'h0);
        rdchk("R8 aux lo write", 2'd2, 12'h030);
        chk("R8 aux literal", rdata, 32'hDEAD_1111);
        op(1'b1, 1'b1, 2'd1, 12'h030, 32'h0000_2222, 4'h0);
        rdchk("R8 aux hi write", 2'd2, 12'h030);
        chk("R8 aux literal 2", rdata, 32'h2222_1111);

        // Unmapped and reserved size (R10)
        rdchk("R10 unmapped", 2'd1, 12'h002);
        rdchk("R10 unmapped", 2'd2, 12'h040);
        rdchk("R10 unmapped", 2'd0, 12'h801);
        rdchk("R10 unmapped", 2'd1, 12'hFFE);
        rdchk("R10 reserved size read", 2'd3, 12'h030);
        chk("R10 reserved literal", rdata, 32'h0);
        op(1'b1, 1'b1, 2'd3, 12'h030, 32'h7777_7777, 4'h0);
        rdchk("R10 reserved size write", 2'd2, 12'h030);
        chk("R10 aux untouched", rdata, 32'h2222_1111);

        // Read data holds without a read (R11)
        rdchk("R11 before hold", 2'd1, 12'h000);
        held = rdata;
        op(1'b1, 1'b1, 2'd1, 12'h030, 32'h0000_ABCD, 4'h0);
        op(1'b0, 1'b0, 2'd1, 12'h030, 32'h0, 4'h0);
        chk("R11 rdata held", rdata, held);

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

endmodule